// File: doc/BRIEF.md
# USB Host Clock and Reset Bring-Up Sequencer

This block walks a USB host controller and its PHY out of reset in hardware, in place of a stepwise software routine. Two host clients share it: a high-speed (EHCI-style) host and a full/low-speed (OHCI-style) host. Each client raises a one-cycle start request when it powers on and a one-cycle stop request when it powers off. A use count shared by both clients ensures that only the request that takes the count from zero to one launches the sequence. Later starts only add to the count.

Once launched, the sequencer turns on the interface clock enable. It then checks a readback of the host-reset field. If the host is already out of reset, it goes straight to port tuning. Otherwise it runs the full ordered programming of the clock dividers, the PHY power-on reset, the test-equipment reset pulse, the PHY reset and the host reset. Every wait is counted in I/O clock cycles, and the cycle counts are derived at elaboration from the I/O clock frequency, rounded up. The host clock divider is also chosen at elaboration, from a banded mapping of the I/O clock frequency. The sequence ends with a tuning write for each PHY port and one write of the micro-frame length adjust value. A done flag then rises and stays high.

Top module: `usbh_clkrst_seq`

## Requirements
- R1: After reset, every control output, every strobe and the done flag are 0.
- R2: The use count adds one for each start request and subtracts one for each stop request in a cycle. A start and a stop in the same cycle cancel. A stop at count zero leaves the count at zero. The sequence launches only when the count moves from zero to non-zero.
- R3: Start requests that arrive while the sequence runs raise the count but neither restart nor disturb the sequence.
- R4: The first action of a run is to set if_en. If host_rst_rb reads 1 at the check that follows, the run skips every reset and clock step and goes directly to port tuning, leaving the reset outputs untouched.
- R5: The reset-configuration step sets phy_por to 1 and drives host_rst, phy_rst, hdiv_en, hdiv_rst, odiv_en, odiv_rst low, with refclk_sel = 0 and refclk_div = 0.
- R6: hdiv_val is taken from q = IO_CLK_HZ / 130 MHz as follows: q = 0 gives 1; q from 1 to 4 gives q; q = 5 gives 4; q = 6 or 7 gives 6; q from 8 to 11 gives 8; q of 12 or more gives 12. At 700 MHz the value is 4.
- R7: hdiv_val is written, then hdiv_en rises, then hdiv_rst rises. phy_por falls no sooner than 64 cycles after hdiv_rst rises.
- R8: ate_rst rises at least ceil(PHY_SETTLE_NS) cycles after phy_por falls. It stays high for at least ceil(10 ns) cycles. At least ceil(20 ns) cycles pass after ate_rst falls before the next step.
- R9: After that, odiv_rst rises, then odiv_en rises. phy_rst rises at least 64 cycles after odiv_en. host_rst rises at least ceil(1 us) cycles after phy_rst.
- R10: Port tuning gives one tune_wr pulse per port, with tune_port counting 0 to NUM_PORTS-1 and tune_vref = 15, tune_rise = 1, tune_preemph = 1. A single fla_wr pulse with fla_val = 0x20 follows the last tuning pulse.
- R11: done rises in the cycle after fla_wr and holds until reset. A new zero-to-non-zero launch after done reruns the sequence from the R4 step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | I/O clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hs_start | input | 1 | High-speed host start request (one cycle) |
| hs_stop | input | 1 | High-speed host stop request (one cycle) |
| fs_start | input | 1 | Full-speed host start request (one cycle) |
| fs_stop | input | 1 | Full-speed host stop request (one cycle) |
| host_rst_rb | input | 1 | Readback of the current host-reset field |
| if_en | output | 1 | Interface clock enable |
| phy_por | output | 1 | PHY power-on reset |
| phy_rst | output | 1 | PHY reset release |
| host_rst | output | 1 | Host reset release |
| hdiv_en | output | 1 | Host clock divider enable |
| hdiv_rst | output | 1 | Host clock divider reset release |
| hdiv_val | output | 4 | Host clock divider ratio |
| odiv_en | output | 1 | Full-speed clock divider enable |
| odiv_rst | output | 1 | Full-speed clock divider reset release |
| ate_rst | output | 1 | PHY test-equipment reset pulse |
| refclk_sel | output | 2 | Reference clock select |
| refclk_div | output | 2 | Reference clock divider |
| tune_wr | output | 1 | Port tuning write strobe |
| tune_port | output | PORT_W | Port addressed by tune_wr |
| tune_vref | output | 4 | Transmit voltage-reference tune value |
| tune_rise | output | 2 | Transmit rise-time tune value |
| tune_preemph | output | 2 | Transmit pre-emphasis tune value |
| fla_wr | output | 1 | Micro-frame length adjust write strobe |
| fla_val | output | 6 | Micro-frame length adjust value |
| done | output | 1 | Bring-up finished, held until reset |

## Verification
The assertions check several orderings on every cycle. phy_por may only fall while both host-divider controls are set. host_rst may only rise once the PHY reset and both full-speed divider controls are up. The PHY settle window is measured with a counter. done never falls, the two write strobes never overlap, and hdiv_val stays inside the legal set. Other behaviour shows up only in the bench scenarios, where a scoreboard compares the full event order and the cycle gaps: the use-count arithmetic (cancelling start and stop, saturation at zero, counting during a run), the rerun after done, and the skip path taken when the readback reports the host already out of reset.

// File: rtl/usbh_seq_pkg.sv
package usbh_seq_pkg;

   typedef enum logic [4:0] {
      ST_IDLE, ST_IFEN, ST_CHK, ST_CFG, ST_HDIV, ST_HDEN, ST_HDRST, ST_WDIVH,
      ST_PORCLR, ST_WPHY, ST_ATEON, ST_WATE, ST_ATEOFF, ST_WCLK, ST_ODRST,
      ST_ODEN, ST_WDIVO, ST_PRST, ST_WPRST, ST_HRST, ST_TUNE, ST_FLA, ST_DONE
   } seq_st_t;

   // Banded host divider choice from the integer ratio io_clk / 130 MHz.
   function automatic logic [3:0] pick_hdiv(longint q);
      if (q <= 0)       return 4'd1;
      else if (q <= 4)  return 4'(q);
      else if (q == 5)  return 4'd4;
      else if (q <= 7)  return 4'd6;
      else if (q <= 11) return 4'd8;
      else              return 4'd12;
   endfunction

   // Minimum cycle count covering a delay, rounded up, never below one.
   function automatic longint ns_cycles(longint ns, longint hz);
      longint c;
      c = (ns * hz + 64'd999_999_999) / 64'd1_000_000_000;
      return (c < 1) ? 64'd1 : c;
   endfunction

endpackage

// File: rtl/usbh_use_counter.sv
module usbh_use_counter #(
   parameter int CNT_W = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_a,
   input  logic stop_a,
   input  logic start_b,
   input  logic stop_b,
   output logic launch
);
   localparam int CMAX = (2 ** CNT_W) - 1;

   logic [CNT_W-1:0] cnt_q, cnt_d;
   int sum;

   always_comb begin
      sum = int'(cnt_q) + int'(start_a) + int'(start_b)
          - int'(stop_a) - int'(stop_b);
      if (sum < 0)          cnt_d = '0;
      else if (sum > CMAX)  cnt_d = CNT_W'(CMAX);
      else                  cnt_d = sum[CNT_W-1:0];
   end

   assign launch = (cnt_q == '0) && (cnt_d != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
   end
endmodule

// File: rtl/usbh_wait_timer.sv
module usbh_wait_timer #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         expired
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt_q <= '0;
      else if (load)        cnt_q <= load_val;
      else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);
endmodule

// File: rtl/usbh_clkrst_seq.sv
module usbh_clkrst_seq
   import usbh_seq_pkg::*;
#(
   parameter longint IO_CLK_HZ     = 800_000_000,
   parameter longint PHY_SETTLE_NS = 1_000_000,
   parameter longint ATE_PULSE_NS  = 10,
   parameter longint PHY_CLK_NS    = 20,
   parameter longint PRST_HOLD_NS  = 1_000,
   parameter int     DIV_SYNC_CYC  = 64,
   parameter int     NUM_PORTS     = 2,
   parameter int     CNT_W         = 4,
   parameter int     TUNE_VREF     = 15,
   parameter int     TUNE_RISE     = 1,
   parameter int     TUNE_PREEMPH  = 1,
   parameter int     FLA_VALUE     = 32,
   localparam int    PORT_W        = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hs_start,
   input  logic              hs_stop,
   input  logic              fs_start,
   input  logic              fs_stop,
   input  logic              host_rst_rb,
   output logic              if_en,
   output logic              phy_por,
   output logic              phy_rst,
   output logic              host_rst,
   output logic              hdiv_en,
   output logic              hdiv_rst,
   output logic [3:0]        hdiv_val,
   output logic              odiv_en,
   output logic              odiv_rst,
   output logic              ate_rst,
   output logic [1:0]        refclk_sel,
   output logic [1:0]        refclk_div,
   output logic              tune_wr,
   output logic [PORT_W-1:0] tune_port,
   output logic [3:0]        tune_vref,
   output logic [1:0]        tune_rise,
   output logic [1:0]        tune_preemph,
   output logic              fla_wr,
   output logic [5:0]        fla_val,
   output logic              done
);
   localparam longint WAIT_DIV  = longint'(DIV_SYNC_CYC);
   localparam longint WAIT_PHY  = ns_cycles(PHY_SETTLE_NS, IO_CLK_HZ);
   localparam longint WAIT_ATE  = ns_cycles(ATE_PULSE_NS, IO_CLK_HZ);
   localparam longint WAIT_CLK  = ns_cycles(PHY_CLK_NS, IO_CLK_HZ);
   localparam longint WAIT_PRST = ns_cycles(PRST_HOLD_NS, IO_CLK_HZ);
   localparam longint WMAX_A    = (WAIT_PHY > WAIT_PRST) ? WAIT_PHY : WAIT_PRST;
   localparam longint WMAX      = (WMAX_A > WAIT_DIV) ? WMAX_A : WAIT_DIV;
   localparam int     TMR_W     = $clog2(WMAX + 1);
   localparam logic [3:0] HDIV_SEL = pick_hdiv(IO_CLK_HZ / 64'd130_000_000);

   // Elaboration-time parameter checks
   if (NUM_PORTS < 1 || NUM_PORTS > 16) begin : g_bad_ports
      $error("NUM_PORTS out of range");
   end
   if (TUNE_VREF > 15 || TUNE_RISE > 3 || TUNE_PREEMPH > 3 || FLA_VALUE > 63) begin : g_bad_tune
      $error("tuning value exceeds field width");
   end
   if (DIV_SYNC_CYC < 1 || CNT_W < 2) begin : g_bad_misc
      $error("DIV_SYNC_CYC or CNT_W too small");
   end

   seq_st_t            st;
   logic               launch;
   logic               tmr_load, tmr_exp;
   logic [TMR_W-1:0]   tmr_val;
   logic [PORT_W-1:0]  port_idx;
   logic               last_port;

   usbh_use_counter #(.CNT_W(CNT_W)) u_use (
      .clk(clk), .rst_n(rst_n),
      .start_a(hs_start), .stop_a(hs_stop),
      .start_b(fs_start), .stop_b(fs_stop),
      .launch(launch)
   );

   usbh_wait_timer #(.W(TMR_W)) u_tmr (
      .clk(clk), .rst_n(rst_n),
      .load(tmr_load), .load_val(tmr_val), .expired(tmr_exp)
   );

   if (NUM_PORTS == 1) begin : g_one_port
      assign last_port = 1'b1;
   end else begin : g_multi_port
      assign last_port = (port_idx == PORT_W'(NUM_PORTS - 1));
   end

   always_comb begin
      tmr_load = 1'b1;
      unique case (st)
         ST_HDRST:  tmr_val = TMR_W'(WAIT_DIV - 1);
         ST_PORCLR: tmr_val = TMR_W'(WAIT_PHY - 1);
         ST_ATEON:  tmr_val = TMR_W'(WAIT_ATE - 1);
         ST_ATEOFF: tmr_val = TMR_W'(WAIT_CLK - 1);
         ST_ODEN:   tmr_val = TMR_W'(WAIT_DIV - 1);
         ST_PRST:   tmr_val = TMR_W'(WAIT_PRST - 1);
         default: begin
            tmr_load = 1'b0;
            tmr_val  = '0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= ST_IDLE;
         if_en      <= 1'b0;
         phy_por    <= 1'b0;
         phy_rst    <= 1'b0;
         host_rst   <= 1'b0;
         hdiv_en    <= 1'b0;
         hdiv_rst   <= 1'b0;
         hdiv_val   <= '0;
         odiv_en    <= 1'b0;
         odiv_rst   <= 1'b0;
         ate_rst    <= 1'b0;
         refclk_sel <= '0;
         refclk_div <= '0;
         tune_wr    <= 1'b0;
         tune_port  <= '0;
         fla_wr     <= 1'b0;
         done       <= 1'b0;
         port_idx   <= '0;
      end else begin
         tune_wr <= 1'b0;
         fla_wr  <= 1'b0;
         unique case (st)
            ST_IDLE:   if (launch) st <= ST_IFEN;
            ST_IFEN: begin
               if_en <= 1'b1;
               st    <= ST_CHK;
            end
            ST_CHK:    st <= host_rst_rb ? ST_TUNE : ST_CFG;
            ST_CFG: begin
               phy_por    <= 1'b1;
               host_rst   <= 1'b0;
               phy_rst    <= 1'b0;
               hdiv_en    <= 1'b0;
               hdiv_rst   <= 1'b0;
               odiv_en    <= 1'b0;
               odiv_rst   <= 1'b0;
               refclk_sel <= 2'd0;
               refclk_div <= 2'd0;
               st         <= ST_HDIV;
            end
            ST_HDIV: begin
               hdiv_val <= HDIV_SEL;
               st       <= ST_HDEN;
            end
            ST_HDEN: begin
               hdiv_en <= 1'b1;
               st      <= ST_HDRST;
            end
            ST_HDRST: begin
               hdiv_rst <= 1'b1;
               st       <= ST_WDIVH;
            end
            ST_WDIVH:  if (tmr_exp) st <= ST_PORCLR;
            ST_PORCLR: begin
               phy_por <= 1'b0;
               st      <= ST_WPHY;
            end
            ST_WPHY:   if (tmr_exp) st <= ST_ATEON;
            ST_ATEON: begin
               ate_rst <= 1'b1;
               st      <= ST_WATE;
            end
            ST_WATE:   if (tmr_exp) st <= ST_ATEOFF;
            ST_ATEOFF: begin
               ate_rst <= 1'b0;
               st      <= ST_WCLK;
            end
            ST_WCLK:   if (tmr_exp) st <= ST_ODRST;
            ST_ODRST: begin
               odiv_rst <= 1'b1;
               st       <= ST_ODEN;
            end
            ST_ODEN: begin
               odiv_en <= 1'b1;
               st      <= ST_WDIVO;
            end
            ST_WDIVO:  if (tmr_exp) st <= ST_PRST;
            ST_PRST: begin
               phy_rst <= 1'b1;
               st      <= ST_WPRST;
            end
            ST_WPRST:  if (tmr_exp) st <= ST_HRST;
            ST_HRST: begin
               host_rst <= 1'b1;
               st       <= ST_TUNE;
            end
            ST_TUNE: begin
               tune_wr   <= 1'b1;
               tune_port <= port_idx;
               if (last_port) begin
                  port_idx <= '0;
                  st       <= ST_FLA;
               end else begin
                  port_idx <= port_idx + 1'b1;
               end
            end
            ST_FLA: begin
               fla_wr <= 1'b1;
               st     <= ST_DONE;
            end
            ST_DONE: begin
               done <= 1'b1;
               if (launch) st <= ST_IFEN;
            end
            default:   st <= ST_IDLE;
         endcase
      end
   end

   assign tune_vref    = tune_wr ? 4'(TUNE_VREF)    : 4'd0;
   assign tune_rise    = tune_wr ? 2'(TUNE_RISE)    : 2'd0;
   assign tune_preemph = tune_wr ? 2'(TUNE_PREEMPH) : 2'd0;
   assign fla_val      = fla_wr  ? 6'(FLA_VALUE)    : 6'd0;

endmodule

// File: rtl/usbh_seq_chk.sv
module usbh_seq_chk #(
   parameter longint WAIT_PHY = 1
) (
   input logic       clk,
   input logic       rst_n,
   input logic       if_en,
   input logic       phy_por,
   input logic       phy_rst,
   input logic       host_rst,
   input logic       hdiv_en,
   input logic       hdiv_rst,
   input logic [3:0] hdiv_val,
   input logic       odiv_en,
   input logic       odiv_rst,
   input logic       ate_rst,
   input logic       tune_wr,
   input logic       fla_wr,
   input logic       done
);
   logic [31:0] since_por;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  since_por <= '0;
      else if (phy_por)            since_por <= '0;
      else if (since_por != '1)    since_por <= since_por + 1'b1;
   end

   assert_por_after_hdiv_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(phy_por) |-> (hdiv_en && hdiv_rst));

   assert_settle_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ate_rst) |-> (64'(since_por) >= WAIT_PHY));

   assert_ate_outside_por_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ate_rst |-> !phy_por);

   assert_host_release_order_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(host_rst) |-> (phy_rst && odiv_en && odiv_rst && !phy_por));

   assert_hdiv_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
      hdiv_en |-> (hdiv_val inside {4'd1, 4'd2, 4'd3, 4'd4, 4'd6, 4'd8, 4'd12}));

   assert_ifen_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (phy_por || tune_wr || fla_wr) |-> if_en);

   assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({tune_wr, fla_wr}));

   assert_fla_follows_tune_R10: assert property (@(posedge clk) disable iff (!rst_n)
      fla_wr |-> $past(tune_wr));

   assert_done_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> done);

endmodule

bind usbh_clkrst_seq usbh_seq_chk #(.WAIT_PHY(WAIT_PHY)) u_chk (
   .clk(clk), .rst_n(rst_n), .if_en(if_en), .phy_por(phy_por),
   .phy_rst(phy_rst), .host_rst(host_rst), .hdiv_en(hdiv_en),
   .hdiv_rst(hdiv_rst), .hdiv_val(hdiv_val), .odiv_en(odiv_en),
   .odiv_rst(odiv_rst), .ate_rst(ate_rst), .tune_wr(tune_wr),
   .fla_wr(fla_wr), .done(done)
);

// File: tb/sim_usbh_clkrst_seq.sv
module sim_usbh_clkrst_seq;
   localparam int CLK_P = 10;

   // Expected cycle counts at 700 MHz, worked out by hand from the requirements
   localparam int E_DIV  = 64;
   localparam int E_PHY  = 7000;  // 10 us
   localparam int E_ATE  = 7;     // 10 ns
   localparam int E_CLK  = 14;    // 20 ns
   localparam int E_PRST = 700;   // 1 us
   localparam int E_HDIV = 4;     // 700/130 = 5 -> 4

   logic clk = 1'b0, rst_n = 1'b0;
   logic hs_start = 0, hs_stop = 0, fs_start = 0, fs_stop = 0, rb_force = 0;
   logic if_en, phy_por, phy_rst, host_rst, hdiv_en, hdiv_rst, odiv_en, odiv_rst, ate_rst;
   logic [3:0] hdiv_val, tune_vref;
   logic [1:0] refclk_sel, refclk_div, tune_rise, tune_preemph;
   logic tune_wr, fla_wr, done;
   logic [0:0] tune_port;
   logic [5:0] fla_val;

   int checks = 0, fails = 0;
   int exp_q[$];
   string tag_q[$];
   longint cyc = 0;
   longint t_hdrst, t_porf, t_ater, t_atef, t_oden, t_prst;
   bit finished = 0;

   always #(CLK_P/2) clk = ~clk;

   usbh_clkrst_seq #(.IO_CLK_HZ(700_000_000), .PHY_SETTLE_NS(10_000)) u0 (
      .clk(clk), .rst_n(rst_n), .hs_start(hs_start), .hs_stop(hs_stop),
      .fs_start(fs_start), .fs_stop(fs_stop), .host_rst_rb(host_rst | rb_force),
      .if_en(if_en), .phy_por(phy_por), .phy_rst(phy_rst), .host_rst(host_rst),
      .hdiv_en(hdiv_en), .hdiv_rst(hdiv_rst), .hdiv_val(hdiv_val),
      .odiv_en(odiv_en), .odiv_rst(odiv_rst), .ate_rst(ate_rst),
      .refclk_sel(refclk_sel), .refclk_div(refclk_div), .tune_wr(tune_wr),
      .tune_port(tune_port), .tune_vref(tune_vref), .tune_rise(tune_rise),
      .tune_preemph(tune_preemph), .fla_wr(fla_wr), .fla_val(fla_val), .done(done)
   );

   task automatic chk(bit ok, string req, longint act, longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Driver side of the scoreboard
   task automatic push(int code, string req);
      exp_q.push_back(code);
      tag_q.push_back(req);
   endtask

   task automatic push_full();
      push(1, "R4");  push(2, "R5");  push(3, "R6");  push(4, "R7");
      push(5, "R7");  push(6, "R7");  push(7, "R8");  push(8, "R8");
      push(9, "R9");  push(10, "R9"); push(11, "R9"); push(12, "R9");
      push(20, "R10"); push(21, "R10"); push(30, "R10"); push(31, "R11");
   endtask

   task automatic pulse(bit hs_s, bit hs_p, bit fs_s, bit fs_p);
      @(posedge clk); #1;
      hs_start = hs_s; hs_stop = hs_p; fs_start = fs_s; fs_stop = fs_p;
      @(posedge clk); #1;
      hs_start = 0; hs_stop = 0; fs_start = 0; fs_stop = 0;
   endtask

   task automatic idle(int n);
      repeat (n) @(posedge clk);
   endtask

   task automatic wait_done(int limit);
      int k = 0;
      while (!done && k < limit) begin
         @(negedge clk);
         k++;
      end
      chk(done, "R11 done timeout", done, 1);
   endtask

   // Monitor side: pops one expected event per observed event
   task automatic seen(int code);
      int e; string t;
      if (exp_q.size() == 0) begin
         chk(0, "R3 unexpected event", code, -1);
      end else begin
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         chk(e == code, t, code, e);
      end
   endtask

   logic p_if, p_por, p_hen, p_hrs, p_ate, p_ors, p_oen, p_prs, p_hst, p_done;
   logic [3:0] p_hv;

   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         if (if_en && !p_if)        seen(1);
         if (phy_por && !p_por)     seen(2);
         if (hdiv_val != p_hv) begin
            seen(3);
            chk(hdiv_val == E_HDIV, "R6 hdiv_val", hdiv_val, E_HDIV);
         end
         if (hdiv_en && !p_hen)     seen(4);
         if (hdiv_rst && !p_hrs) begin seen(5); t_hdrst = cyc; end
         if (!phy_por && p_por) begin
            seen(6); t_porf = cyc;
            chk(cyc - t_hdrst >= E_DIV, "R7 por gap", cyc - t_hdrst, E_DIV);
         end
         if (ate_rst && !p_ate) begin
            seen(7); t_ater = cyc;
            chk(cyc - t_porf >= E_PHY && cyc - t_porf <= E_PHY + 3,
                "R8 settle gap", cyc - t_porf, E_PHY);
         end
         if (!ate_rst && p_ate) begin
            seen(8); t_atef = cyc;
            chk(cyc - t_ater >= E_ATE, "R8 ate width", cyc - t_ater, E_ATE);
         end
         if (odiv_rst && !p_ors) begin
            seen(9);
            chk(cyc - t_atef >= E_CLK, "R8 clock gap", cyc - t_atef, E_CLK);
         end
         if (odiv_en && !p_oen) begin seen(10); t_oden = cyc; end
         if (phy_rst && !p_prs) begin
            seen(11); t_prst = cyc;
            chk(cyc - t_oden >= E_DIV, "R9 divider gap", cyc - t_oden, E_DIV);
         end
         if (host_rst && !p_hst) begin
            seen(12);
            chk(cyc - t_prst >= E_PRST, "R9 prst gap", cyc - t_prst, E_PRST);
         end
         if (tune_wr) begin
            seen(20 + int'(tune_port));
            chk({tune_vref, tune_rise, tune_preemph} == {4'd15, 2'd1, 2'd1},
                "R10 tune fields", {tune_vref, tune_rise, tune_preemph},
                {4'd15, 2'd1, 2'd1});
         end
         if (fla_wr) begin
            seen(30);
            chk(fla_val == 6'h20, "R10 fla_val", fla_val, 6'h20);
         end
         if (done && !p_done)       seen(31);
      end
      p_if = if_en; p_por = phy_por; p_hv = hdiv_val; p_hen = hdiv_en;
      p_hrs = hdiv_rst; p_ate = ate_rst; p_ors = odiv_rst; p_oen = odiv_en;
      p_prs = phy_rst; p_hst = host_rst; p_done = done;
   end

   initial begin
      idle(5);
      @(negedge clk);
      chk({if_en, phy_por, phy_rst, host_rst, hdiv_en, hdiv_rst, hdiv_val, odiv_en,
           odiv_rst, ate_rst, tune_wr, fla_wr, done} == '0, "R1 reset outputs", 1, 0);
      @(posedge clk); #1 rst_n = 1;

      // Start and stop together at zero: no launch
      pulse(1, 1, 0, 0);
      idle(20); @(negedge clk);
      chk(if_en == 0, "R2 cancelled start", if_en, 0);
      // Stop at zero: saturates
      pulse(0, 0, 0, 1);
      idle(5);

      // Full run, with an extra start in the middle
      push_full();
      pulse(1, 0, 0, 0);
      idle(30);
      pulse(0, 0, 1, 0);
      wait_done(20000);
      idle(5); @(negedge clk);
      chk(exp_q.size() == 0, "R3 no restart", exp_q.size(), 0);
      chk(refclk_sel == 0 && refclk_div == 0, "R5 refclk", {refclk_sel, refclk_div}, 0);
      chk(hdiv_val == E_HDIV, "R6 final hdiv", hdiv_val, E_HDIV);

      // Both stop (count 0), then an extra stop; the next start must relaunch
      pulse(0, 1, 0, 1);
      pulse(0, 0, 0, 1);
      idle(10); @(negedge clk);
      chk(done == 1, "R11 done held", done, 1);
      push(20, "R2"); push(21, "R2"); push(30, "R11");
      pulse(1, 0, 0, 0);
      idle(40); @(negedge clk);
      chk(exp_q.size() == 0, "R2 relaunch after saturation", exp_q.size(), 0);

      // Reset with readback already set: skip path
      @(posedge clk); #1 rst_n = 0; rb_force = 1;
      idle(3); @(negedge clk);
      chk(done == 0, "R11 done cleared by reset", done, 0);
      @(posedge clk); #1 rst_n = 1;
      push(1, "R4"); push(20, "R4"); push(21, "R4"); push(30, "R4"); push(31, "R4");
      pulse(0, 0, 1, 0);
      idle(40); @(negedge clk);
      chk(exp_q.size() == 0, "R4 skip events", exp_q.size(), 0);
      chk(host_rst == 0 && phy_por == 0, "R4 resets untouched", {host_rst, phy_por}, 0);
      chk(done == 1, "R11 done after skip", done, 1);

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (100_000) @(posedge clk);
      if (!finished) begin
         checks++; fails++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule